// File: doc/BRIEF.md
# GPIO Controller with Edge-Event Interrupts

A 32-pin general-purpose I/O block behind a simple word-wide register port. Software picks, pin by pin, whether the pin drives a value or senses one. Sensed pins pass through a two-stage synchronizer. The sampled level is copied into the data register, and a level change can latch an event bit. A per-pin control bit chooses whether every change counts, or only a high-to-low change. A single interrupt line is high while any latched event is also enabled by the mask register.

The register port takes one request per cycle: a valid strobe, a write flag, a full-word flag, a byte address and write data. Read data comes back registered one cycle after the request. The address is the offset inside the block; an upstream decoder has already removed the base. Pad electrics are outside this block. The open-drain selection is only stored and exported to the pad ring.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After reset every register reads zero, all pin outputs, direction and open-drain outputs are low, and `irq_o` is low.
- R2: Register offsets are 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask, 0x14 control. Pin n occupies register bit 31-n, so pin 0 is bit 31. Port vectors are indexed by pin number.
- R3: A direction bit of 1 makes the pin an output and 0 makes it an input. For input pins, the data register bit follows the synchronized external level; a level change is visible in the register two clock edges after the edge that first samples it.
- R4: A data write changes the drive value `pin_out_o` only for pins whose direction bit is 1. Drive values of the other pins keep their previous value.
- R5: For an input pin whose control bit is 0, any change of the synchronized level sets its event bit.
- R6: For an input pin whose control bit is 1, only a 1-to-0 change of the synchronized level sets its event bit; a 0-to-1 change does not.
- R7: Writing the event register clears each bit written as 1 and leaves each bit written as 0 unchanged. Event bits never clear otherwise.
- R8: When a new event for a pin arrives on the same edge as a clear of that bit, the bit stays set.
- R9: `irq_o` is high exactly while (event AND mask) is nonzero. It changes on the same edge as the register that causes the change.
- R10: A request with `req_full_i` low does not change any register and reads as zero. A read of an offset not listed in R2 returns zero.
- R11: `rsp_rdata_o` carries the register value read on the edge of the request and is visible after that edge. It is zero in cycles that follow no valid full-word read.
- R12: Level changes on pins whose direction bit is 1 never set event bits.
- R13: The open-drain register holds the value written and is presented per pin on `pin_od_o`, and the direction register per pin on `pin_dir_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, one cycle per access |
| req_write_i | input | 1 | 1 write, 0 read |
| req_full_i | input | 1 | 1 when the access is a full 32-bit word |
| req_addr_i | input | 32 | Byte offset inside the block |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Registered read data |
| pin_in_i | input | 32 | External pin levels, index = pin number |
| pin_out_o | output | 32 | Drive values, index = pin number |
| pin_dir_o | output | 32 | 1 = pin is an output, index = pin number |
| pin_od_o | output | 32 | Open-drain select, index = pin number |
| irq_o | output | 1 | Interrupt, high while an unmasked event is latched |

## Verification
A pin change applied before clock edge k reaches the data and event registers on edge k+2. Write effects and `irq_o` settle on the edge that accepts the write, and read data appears after the edge that takes the request. The bench model carries a three-deep history of pin levels and applies each register update on the matching edge. Outputs are compared on every falling clock edge, halfway between updates. The directed steps wait whole cycles before reading back, and one step places an event clear on exactly edge k+2 to exercise R8.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int unsigned OFS_DIR = 32'h00;
  localparam int unsigned OFS_ODR = 32'h04;
  localparam int unsigned OFS_DAT = 32'h08;
  localparam int unsigned OFS_EVT = 32'h0C;
  localparam int unsigned OFS_MSK = 32'h10;
  localparam int unsigned OFS_CTL = 32'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_ODR,
    SEL_DAT,
    SEL_EVT,
    SEL_MSK,
    SEL_CTL
  } reg_sel_e;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] raw_i,
  output logic [DW-1:0] lvl_o,
  output logic [DW-1:0] prev_o
);
  logic [DW-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_evt_latch.sv
module gpio_evt_latch #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] lvl_i,
  input  logic [DW-1:0] prev_i,
  input  logic [DW-1:0] dir_i,
  input  logic [DW-1:0] ctl_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] ev_o
);
  logic [DW-1:0] ev_q, set_w;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    logic chg, fall;
    assign chg  = lvl_i[b] ^ prev_i[b];
    assign fall = prev_i[b] & ~lvl_i[b];
    // ctl 0: any change, ctl 1: falling only; outputs never raise events
    assign set_w[b] = ~dir_i[b] & (ctl_i[b] ? fall : chg);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_q <= '0;
    else         ev_q <= (ev_q & ~clr_i) | set_w;
  end

  assign ev_o = ev_q;

  AST_EVT_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ev_q & $past(clr_i & ~set_w)) == '0)); // R7
  AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~ev_q & $past(ev_q) & ~$past(clr_i)) == '0)); // R7
  AST_EVT_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ev_q & $past(set_w)) == $past(set_w))); // R8
  AST_EVT_INPUT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ev_q & ~$past(ev_q) & $past(dir_i)) == '0)); // R12
  AST_EVT_FALL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ev_q & ~$past(ev_q) & $past(ctl_i) & ~($past(prev_i) & ~$past(lvl_i))) == '0)); // R6
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          req_full_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] lvl_i,
  input  logic [DW-1:0] ev_i,
  output logic [DW-1:0] dir_o,
  output logic [DW-1:0] od_o,
  output logic [DW-1:0] msk_o,
  output logic [DW-1:0] ctl_o,
  output logic [DW-1:0] out_o,
  output logic [DW-1:0] clr_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] dir_q, od_q, dat_q, msk_q, ctl_q, out_q, rdata_q;
  logic [DW-1:0] dat_w, rd_mux;
  logic          wr_ok, rd_ok;
  reg_sel_e      sel;

  assign wr_ok = req_valid_i & req_write_i & req_full_i;
  assign rd_ok = req_valid_i & ~req_write_i & req_full_i;

  always_comb begin
    sel = SEL_NONE;
    if      (req_addr_i == AW'(OFS_DIR)) sel = SEL_DIR;
    else if (req_addr_i == AW'(OFS_ODR)) sel = SEL_ODR;
    else if (req_addr_i == AW'(OFS_DAT)) sel = SEL_DAT;
    else if (req_addr_i == AW'(OFS_EVT)) sel = SEL_EVT;
    else if (req_addr_i == AW'(OFS_MSK)) sel = SEL_MSK;
    else if (req_addr_i == AW'(OFS_CTL)) sel = SEL_CTL;
  end

  always_comb begin
    unique case (sel)
      SEL_DIR: rd_mux = dir_q;
      SEL_ODR: rd_mux = od_q;
      SEL_DAT: rd_mux = dat_q;
      SEL_EVT: rd_mux = ev_i;
      SEL_MSK: rd_mux = msk_q;
      SEL_CTL: rd_mux = ctl_q;
      default: rd_mux = '0;
    endcase
  end

  assign dat_w = (wr_ok && sel == SEL_DAT) ? req_wdata_i : dat_q;
  assign clr_o = (wr_ok && sel == SEL_EVT) ? req_wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      od_q    <= '0;
      dat_q   <= '0;
      msk_q   <= '0;
      ctl_q   <= '0;
      out_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_ok && sel == SEL_DIR) dir_q <= req_wdata_i;
      if (wr_ok && sel == SEL_ODR) od_q  <= req_wdata_i;
      if (wr_ok && sel == SEL_MSK) msk_q <= req_wdata_i;
      if (wr_ok && sel == SEL_CTL) ctl_q <= req_wdata_i;
      // input bits always track the sampled level
      dat_q <= (dat_w & dir_q) | (lvl_i & ~dir_q);
      if (wr_ok && sel == SEL_DAT) out_q <= (out_q & ~dir_q) | (req_wdata_i & dir_q);
      rdata_q <= rd_ok ? rd_mux : '0;
    end
  end

  assign dir_o   = dir_q;
  assign od_o    = od_q;
  assign msk_o   = msk_q;
  assign ctl_o   = ctl_q;
  assign out_o   = out_q;
  assign rdata_o = rdata_q;

  AST_OUT_INPUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0)); // R4
  AST_PARTIAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_full_i) |=> ($stable(dir_q) && $stable(od_q) && $stable(msk_q) && $stable(ctl_q) && $stable(out_q))); // R10
  AST_PARTIAL_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_full_i) |=> (rdata_q == '0)); // R10
  AST_IDLE_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i || req_write_i) |=> (rdata_q == '0)); // R11
endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          req_full_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic [DW-1:0] rsp_rdata_o,
  input  logic [DW-1:0] pin_in_i,
  output logic [DW-1:0] pin_out_o,
  output logic [DW-1:0] pin_dir_o,
  output logic [DW-1:0] pin_od_o,
  output logic          irq_o
);
  logic [DW-1:0] raw_w, lvl_w, prev_w, ev_w, clr_w;
  logic [DW-1:0] dir_w, od_w, msk_w, ctl_w, out_w;

  // pin n <-> register bit DW-1-n
  for (genvar n = 0; n < DW; n++) begin : g_pin
    assign raw_w[DW-1-n] = pin_in_i[n];
    assign pin_out_o[n]  = out_w[DW-1-n];
    assign pin_dir_o[n]  = dir_w[DW-1-n];
    assign pin_od_o[n]   = od_w[DW-1-n];
  end

  gpio_evt_sync #(.DW(DW)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw_w),
    .lvl_o  (lvl_w),
    .prev_o (prev_w)
  );

  gpio_evt_latch #(.DW(DW)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl_w),
    .prev_i (prev_w),
    .dir_i  (dir_w),
    .ctl_i  (ctl_w),
    .clr_i  (clr_w),
    .ev_o   (ev_w)
  );

  gpio_evt_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_full_i  (req_full_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .lvl_i       (lvl_w),
    .ev_i        (ev_w),
    .dir_o       (dir_w),
    .od_o        (od_w),
    .msk_o       (msk_w),
    .ctl_o       (ctl_w),
    .out_o       (out_w),
    .clr_o       (clr_w),
    .rdata_o     (rsp_rdata_o)
  );

  assign irq_o = |(ev_w & msk_w);

  AST_IRQ_FROM_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_full_i && req_addr_i == AW'(32'h10) && req_wdata_i == '0 && clr_w == '0)
      |=> !irq_o); // R9
endmodule

// File: tb/gpio_evt_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_evt_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_full = 1'b1;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [31:0] rdata, pin_in = '0, pin_out, pin_dir, pin_od;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_evt_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_full_i(req_full),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_rdata_o(rdata),
    .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_dir_o(pin_dir), .pin_od_o(pin_od),
    .irq_o(irq)
  );

  function automatic logic [31:0] flip(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model (register bit order) ----------------
  logic [31:0] m_dir, m_od, m_dat, m_ev, m_msk, m_ctl, m_out, m_rd;
  logic [31:0] hist [3];

  function automatic logic [31:0] m_read(input logic [31:0] a);
    case (a)
      32'h00: return m_dir;
      32'h04: return m_od;
      32'h08: return m_dat;
      32'h0C: return m_ev;
      32'h10: return m_msk;
      32'h14: return m_ctl;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_dir, m_od, m_dat, m_ev, m_msk, m_ctl, m_out, m_rd} = '0;
      for (int i = 0; i < 3; i++) hist[i] = '0;
    end else begin
      logic [31:0] cur, old, setm, clr, dw;
      logic wr, rd;
      cur = hist[1];
      old = hist[2];
      wr = req_valid && req_write && req_full;
      rd = req_valid && !req_write && req_full;
      clr = (wr && req_addr == 32'h0C) ? req_wdata : 32'h0;
      setm = ~m_dir & (cur ^ old) & (~m_ctl | (old & ~cur));
      m_rd = rd ? m_read(req_addr) : 32'h0;
      dw = (wr && req_addr == 32'h08) ? req_wdata : m_dat;
      if (wr && req_addr == 32'h08) m_out = (m_out & ~m_dir) | (req_wdata & m_dir);
      m_dat = (dw & m_dir) | (cur & ~m_dir);
      m_ev = (m_ev & ~clr) | setm;
      if (wr && req_addr == 32'h00) m_dir = req_wdata;
      if (wr && req_addr == 32'h04) m_od = req_wdata;
      if (wr && req_addr == 32'h10) m_msk = req_wdata;
      if (wr && req_addr == 32'h14) m_ctl = req_wdata;
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = flip(pin_in);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R11 rdata", rdata, m_rd);
      check("R4 pin_out", pin_out, flip(m_out));
      check("R13 pin_dir", pin_dir, flip(m_dir));
      check("R13 pin_od", pin_od, flip(m_od));
      check("R9 irq", {31'b0, irq}, {31'b0, |(m_ev & m_msk)});
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d, input logic full = 1'b1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_full = full;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_full = 1'b1;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d, input logic full = 1'b1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_full = full;
    @(negedge clk);
    d = rdata;
    req_valid = 1'b0; req_full = 1'b1;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      bus_rd(32'(a * 4), v);
      check("R1 reg after reset", v, 32'h0);
    end
    check("R1 outputs after reset", pin_out | pin_dir | pin_od, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R13 open-drain register
    bus_wr(32'h04, 32'h1234_5678);
    bus_rd(32'h04, v);
    check("R13 od readback", v, 32'h1234_5678);
    check("R13 od pins", pin_od, flip(32'h1234_5678));

    // R2 R3 R5: pin 0 rises, appears at bit 31
    pin_in[0] = 1'b1;
    settle();
    bus_rd(32'h08, v);
    check("R3 data sample pin0", v, 32'h8000_0000);
    bus_rd(32'h0C, v);
    check("R5 any-edge event pin0", v, 32'h8000_0000);
    check("R9 irq masked off", {31'b0, irq}, 32'h0);

    // R9 unmask
    bus_wr(32'h10, 32'h8000_0000);
    check("R9 irq after mask", {31'b0, irq}, 32'h1);

    // R7 write-one-to-clear
    bus_wr(32'h0C, 32'h7FFF_FFFF);
    bus_rd(32'h0C, v);
    check("R7 zero bits keep event", v, 32'h8000_0000);
    bus_wr(32'h0C, 32'h8000_0000);
    check("R7 irq after clear", {31'b0, irq}, 32'h0);
    bus_rd(32'h0C, v);
    check("R7 cleared", v, 32'h0);

    // R6 falling-only mode
    bus_wr(32'h14, 32'h8000_0000);
    pin_in[0] = 1'b0;
    settle();
    bus_rd(32'h0C, v);
    check("R6 fall sets event", v, 32'h8000_0000);
    bus_wr(32'h0C, 32'hFFFF_FFFF);
    pin_in[0] = 1'b1;
    settle();
    bus_rd(32'h0C, v);
    check("R6 rise ignored", v, 32'h0);

    // R8 new event coincides with clear (event lands on edge k+2)
    bus_wr(32'h14, 32'h0);
    pin_in[0] = 1'b0;
    settle();
    pin_in[0] = 1'b1;
    @(negedge clk);
    bus_wr(32'h0C, 32'h8000_0000);
    bus_rd(32'h0C, v);
    check("R8 set beats clear", v, 32'h8000_0000);

    // R4 output drive gated by direction
    bus_wr(32'h00, 32'h0000_FFFF);
    bus_wr(32'h08, 32'hFFFF_FFFF);
    check("R4 outputs driven", pin_out, 32'hFFFF_0000);
    bus_wr(32'h00, 32'h0);
    bus_wr(32'h08, 32'h0);
    check("R4 inputs hold drive", pin_out, 32'hFFFF_0000);

    // R12 output pins raise no events
    bus_wr(32'h00, 32'hFFFF_FFFF);
    bus_wr(32'h0C, 32'hFFFF_FFFF);
    pin_in[5] = 1'b1;
    pin_in[0] = 1'b0;
    settle();
    bus_rd(32'h0C, v);
    check("R12 no event on outputs", v, 32'h0);

    // R10 partial and unmapped
    bus_wr(32'h10, 32'hFFFF_FFFF, 1'b0);
    bus_rd(32'h10, v);
    check("R10 partial write ignored", v, 32'h8000_0000);
    bus_rd(32'h10, v, 1'b0);
    check("R10 partial read zero", v, 32'h0);
    bus_rd(32'h1C, v);
    check("R10 unmapped read zero", v, 32'h0);

    // R11 idle cycle returns zero
    @(negedge clk);
    check("R11 idle rdata", rdata, 32'h0);

    // random traffic, model compared every cycle
    bus_wr(32'h00, 32'h0F0F_0000);
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) pin_in[$urandom_range(0, 31)] ^= 1'b1;
      if ($urandom_range(0, 2) == 0) begin
        req_valid = 1'b1;
        req_write = 1'($urandom_range(0, 1));
        req_full  = ($urandom_range(0, 7) != 0);
        req_addr  = 32'($urandom_range(0, 7) * 4);
        req_wdata = $urandom;
      end else begin
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule